// File: doc/BRIEF.md
# Byte-Lane Bus Access Controller

This block sits between a processor-side load/store port and a 32-bit memory bus made of four byte-wide banks. A request carries a full byte address, an access size (byte, word or doubleword), a direction flag and write data. The controller turns the request into one or two bus cycles. The bus side has no low address bits. Each cycle carries a doubleword address, four active-low per-bank byte enables and write data placed on the correct lanes.

An access that fits inside one doubleword takes a single bus cycle. A word or doubleword that runs past the end of a doubleword is split into two cycles. The lower doubleword is issued first, then the next one. On reads, the bytes from both cycles are merged into one right-justified result. The processor side takes one request at a time: `req_ready` is high only while the block is idle, and `done` pulses once when the whole access has finished.

Top module: `lane_bus_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `bus_cyc` is 0, `bus_be_n` is 4'b1111 and `done` is 0.
- R2: During a bus cycle `bus_addr` is bits 31..2 of the byte being served. Bits 1..0 of the request address never appear on the bus.
- R3: Lane k is `bus_wdata`/`bus_rdata` bits 8k+7..8k and is enabled by `bus_be_n[k]` = 0. Byte i of the request (byte 0 = least significant) travels on lane (addr[1:0]+i) mod 4. Only lanes the request touches in the current doubleword are enabled.
- R4: On writes, every lane of `bus_wdata` whose enable is inactive carries 8'h00.
- R5: With n the access size in bytes, a request where addr[1:0]+n > 4 takes two bus cycles. The first uses addr[31:2]. The second uses addr[31:2]+1 modulo 2^30 and carries the remaining bytes starting at lane 0.
- R6: On a read, `rdata` holds request byte i in bits 8i+7..8i, with bytes gathered from both cycles of a split access. Bytes at or above n are 0.
- R7: While `bus_cyc` is 1 and `bus_ready` is 0, `bus_addr`, `bus_be_n`, `bus_wdata` and `bus_write` stay unchanged and the cycle stays open.
- R8: `req_ready` is 1 only when no access is in progress. A `req_valid` raised while busy causes no bus cycle and no change.
- R9: `done` is 1 for exactly the one clock following the `bus_ready` that ends the last bus cycle of an access. `rdata` is valid in that clock.
- R10: `req_size` codes: 0 = byte, 1 = word, 2 = doubleword, 3 = handled as doubleword.
- R11: `bus_write` equals the request's write flag in every cycle where `bus_cyc` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-justified |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read result, right-justified |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | 30 | Doubleword address |
| bus_be_n | output | 4 | Active-low byte enables, one per bank |
| bus_write | output | 1 | Cycle direction |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ready | input | 1 | Memory ends the current cycle |
| bus_rdata | input | 32 | Read data from the four banks |

## Verification
The hardest case to reach is a split read at the very top of the address space. Here the second doubleword address must wrap to zero, and the merge must take bytes from both cycles while the memory inserts wait states. The bench reaches it with a doubleword read at FFFFFFFEh. Its memory model responds after several wait cycles and keeps byte contents for the top and bottom doublewords that agree with an independent byte-level reference. A second hard case is a request raised while a long cycle is stalled. The bench holds `req_valid` high during a wait-stated access and then confirms that only one bus cycle was logged.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } bus_state_e;
endpackage

// File: rtl/lane_rst_sync.sv
module lane_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_ns <= meta_q;
    end
  end
endmodule

// File: rtl/lane_plan.sv
module lane_plan #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  output logic [LANES-1:0] keep,
  output logic [LANES-1:0] lo_en,
  output logic [LANES-1:0] hi_en,
  output logic             split
);
  logic [2*LANES-1:0] base;
  logic [2*LANES-1:0] span;
  int size_eff;
  int nbytes;

  always_comb begin
    size_eff = (int'(size) > OFF_W) ? OFF_W : int'(size);
    nbytes   = 1 << size_eff;
    base     = '0;
    for (int i = 0; i < LANES; i++) begin
      base[i] = (i < nbytes);
    end
    span  = base << off;
    keep  = base[LANES-1:0];
    lo_en = span[LANES-1:0];
    hi_en = span[2*LANES-1:LANES];
    split = |hi_en;
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [LANES-1:0]  keep,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lo_wdata,
  output logic [DATA_W-1:0] hi_wdata,
  input  logic [DATA_W-1:0] lo_rd,
  input  logic [DATA_W-1:0] hi_rd,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0]   wmask;
  logic [DATA_W-1:0]   rshift;
  logic [2*DATA_W-1:0] wide_w;
  logic [2*DATA_W-1:0] wide_r;
  int sh;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign wmask[k*LANE_W +: LANE_W] = keep[k] ? wdata[k*LANE_W +: LANE_W]  : '0;
    assign rdata[k*LANE_W +: LANE_W] = keep[k] ? rshift[k*LANE_W +: LANE_W] : '0;
  end

  always_comb begin
    sh       = int'(off) * LANE_W;
    wide_w   = {{DATA_W{1'b0}}, wmask} << sh;
    lo_wdata = wide_w[DATA_W-1:0];
    hi_wdata = wide_w[2*DATA_W-1:DATA_W];
    wide_r   = {hi_rd, lo_rd} >> sh;
    rshift   = wide_r[DATA_W-1:0];
  end
endmodule

// File: rtl/lane_bus_ctrl.sv
module lane_bus_ctrl #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DW_W   = ADDR_W - OFF_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_cyc,
  output logic [DW_W-1:0]   bus_addr,
  output logic [LANES-1:0]  bus_be_n,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);
  import lane_pkg::*;

  logic rst_ns;

  bus_state_e        st_q, st_d;
  logic [DW_W-1:0]   dw_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] lo_rd_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  logic [LANES-1:0]  keep, lo_en, hi_en;
  logic              split;
  logic [DATA_W-1:0] lo_wdata, hi_wdata, merged;
  logic [DATA_W-1:0] lo_src, hi_src;
  logic              cap_req, cap_lo, fin;

  lane_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  lane_plan #(.LANES(LANES)) u_plan (
    .off   (off_q),
    .size  (size_q),
    .keep  (keep),
    .lo_en (lo_en),
    .hi_en (hi_en),
    .split (split)
  );

  lane_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .off      (off_q),
    .keep     (keep),
    .wdata    (wdata_q),
    .lo_wdata (lo_wdata),
    .hi_wdata (hi_wdata),
    .lo_rd    (lo_src),
    .hi_rd    (hi_src),
    .rdata    (merged)
  );

  // read sources: live bus data in the cycle that completes, held low half otherwise
  assign lo_src = (st_q == ST_LO) ? bus_rdata : lo_rd_q;
  assign hi_src = (st_q == ST_HI) ? bus_rdata : '0;

  // next-state and enables
  always_comb begin
    cap_req = (st_q == ST_IDLE) && req_valid;
    cap_lo  = (st_q == ST_LO) && bus_ready && split;
    fin     = bus_ready && (((st_q == ST_LO) && !split) || (st_q == ST_HI));
    st_d    = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_LO;
      ST_LO:   if (bus_ready) st_d = split ? ST_HI : ST_IDLE;
      ST_HI:   if (bus_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      dw_q    <= '0;
      off_q   <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cap_req) begin
      dw_q    <= req_addr[ADDR_W-1:OFF_W];
      off_q   <= req_addr[OFF_W-1:0];
      size_q  <= req_size;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      lo_rd_q <= '0;
    end else if (cap_lo) begin
      lo_rd_q <= bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rdata_q <= '0;
    end else if (fin && !wr_q) begin
      rdata_q <= merged;
    end
  end

  // bus-side decode from held request state
  always_comb begin
    bus_cyc   = (st_q != ST_IDLE);
    bus_write = bus_cyc && wr_q;
    bus_addr  = (st_q == ST_HI) ? dw_q + 1'b1 : dw_q;
    unique case (st_q)
      ST_LO:   begin bus_be_n = ~lo_en; bus_wdata = wr_q ? lo_wdata : '0; end
      ST_HI:   begin bus_be_n = ~hi_en; bus_wdata = wr_q ? hi_wdata : '0; end
      default: begin bus_be_n = '1;     bus_wdata = '0; end
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign done      = done_q;
  assign rdata     = rdata_q;

  AST_IDLE_NO_BE: assert property (@(posedge clk) disable iff (!rst_ns)
    !bus_cyc |-> (bus_be_n == '1)); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_cyc |-> !req_ready); // R8
  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be_n)
                                 && $stable(bus_wdata) && $stable(bus_write))); // R7
  AST_SECOND_DW_NEXT: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_cyc && bus_ready && !bus_be_n[LANES-1] && !done_q && st_q == ST_LO && split)
      |=> (bus_addr == $past(bus_addr) + 1'b1) && !bus_be_n[0]); // R5
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done); // R9
  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_cyc && !$stable(bus_write)) |-> $past(!bus_cyc) || $past(bus_ready)); // R11
  AST_SOME_LANE: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_cyc |-> !$onehot0(~bus_be_n) || ($countones(~bus_be_n) == 1)); // R3
endmodule

// File: tb/tb_lane_bus_ctrl.sv
module tb_lane_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        done;
  logic [31:0] rdata;
  logic        bus_cyc;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;

  int nchk = 0;
  int nfail = 0;

  lane_bus_ctrl dut (.*);

  always #5 clk = ~clk;

  // bench memory: 16 doublewords, indexed by bus_addr[3:0]
  logic [31:0] mem [16];
  logic [7:0]  refb [64];
  int          waits;
  int          cnt;
  logic        hold_bad;
  logic [29:0] snap_a;
  logic [3:0]  snap_b;
  logic [31:0] snap_w;
  logic        snap_r;
  logic [29:0] log_a [4];
  logic [3:0]  log_b [4];
  logic [31:0] log_w [4];
  logic        log_r [4];
  int          nlog;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ready = 1'b0;
      cnt = 0;
    end else if (bus_ready) begin
      bus_ready = 1'b0;
      cnt = 0;
    end else if (bus_cyc) begin
      if (cnt == 0) begin
        snap_a = bus_addr; snap_b = bus_be_n; snap_w = bus_wdata; snap_r = bus_write;
      end else if (snap_a !== bus_addr || snap_b !== bus_be_n ||
                   snap_w !== bus_wdata || snap_r !== bus_write) begin
        hold_bad = 1'b1;
      end
      if (cnt == waits) begin
        if (nlog < 4) begin
          log_a[nlog] = bus_addr; log_b[nlog] = bus_be_n;
          log_w[nlog] = bus_wdata; log_r[nlog] = bus_write;
        end
        nlog++;
        bus_rdata = mem[bus_addr[3:0]];
        if (bus_write) begin
          for (int k = 0; k < 4; k++)
            if (!bus_be_n[k]) mem[bus_addr[3:0]][8*k +: 8] = bus_wdata[8*k +: 8];
        end
        bus_ready = 1'b1;
      end else begin
        cnt++;
      end
    end
  end

  // one access, checked against expectations derived from the byte address
  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input int w, input bit poke);
    int n;
    int t;
    logic [29:0] e_a0;
    logic [3:0]  e_b0, e_b1;
    logic [31:0] e_w0, e_w1, e_rd;
    logic        spl;
    logic [31:0] ab;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4; // R10
    e_a0 = a[31:2];
    e_b0 = 4'hF; e_b1 = 4'hF; e_w0 = '0; e_w1 = '0; e_rd = '0;
    spl = (int'(a[1:0]) + n) > 4;
    for (int i = 0; i < n; i++) begin
      ab = a + 32'(i);
      if (ab[31:2] == e_a0) begin
        e_b0[ab[1:0]] = 1'b0; e_w0[8*ab[1:0] +: 8] = wd[8*i +: 8];
      end else begin
        e_b1[ab[1:0]] = 1'b0; e_w1[8*ab[1:0] +: 8] = wd[8*i +: 8];
      end
      e_rd[8*i +: 8] = refb[ab[5:0]];
    end
    waits = w; nlog = 0; hold_bad = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 busy after accept", {31'b0, req_ready}, 32'd0);
    if (poke) begin
      req_valid = 1'b1; req_addr = a ^ 32'h10; req_write = 1'b1; req_wdata = 32'hDEADBEEF;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk("R9 done seen", {31'b0, done}, 32'd1);
    chk("R5 cycle count", 32'(nlog), spl ? 32'd2 : 32'd1);
    chk("R2 first address", {2'b0, log_a[0]}, {2'b0, e_a0});
    chk("R3 first enables", {28'b0, log_b[0]}, {28'b0, e_b0});
    chk("R11 write flag", {31'b0, log_r[0]}, {31'b0, wr});
    if (wr) chk("R4 first lanes", log_w[0], e_w0);
    if (spl && nlog > 1) begin
      chk("R5 second address", {2'b0, log_a[1]}, {2'b0, e_a0 + 30'd1});
      chk("R5 second enables", {28'b0, log_b[1]}, {28'b0, e_b1});
      if (wr) chk("R4 second lanes", log_w[1], e_w1);
    end
    if (!wr) chk("R6 read merge", rdata, e_rd);
    chk("R7 hold while waiting", {31'b0, hold_bad}, 32'd0);
    @(negedge clk);
    chk("R9 done one clock", {31'b0, done}, 32'd0);
    chk("R8 idle again", {31'b0, req_ready}, 32'd1);
    if (wr) begin
      for (int i = 0; i < n; i++) begin
        ab = a + 32'(i);
        refb[ab[5:0]] = wd[8*i +: 8];
      end
    end
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 no cycle", {31'b0, bus_cyc}, 32'd0);
    chk("R1 enables off", {28'b0, bus_be_n}, 32'hF);
    chk("R1 no done", {31'b0, done}, 32'd0);
  endtask

  task automatic t_aligned;
    access(32'h0000_2000, 2'd2, 1'b1, 32'h1122_3344, 0, 1'b0); // R3 all lanes
    access(32'h0000_2000, 2'd2, 1'b0, 32'h0, 1, 1'b0);         // R6
  endtask

  task automatic t_narrow;
    access(32'h0000_2003, 2'd0, 1'b1, 32'hFFFF_FFAB, 0, 1'b0); // R4 byte on lane 3
    access(32'h0000_2001, 2'd1, 1'b1, 32'h0000_5678, 2, 1'b0); // R3 little-endian word
    access(32'h0000_2001, 2'd0, 1'b0, 32'h0, 0, 1'b0);         // R6 upper zero
  endtask

  task automatic t_split;
    access(32'h0000_2007, 2'd2, 1'b1, 32'hA1B2_C3D4, 1, 1'b0); // R5 dword split
    access(32'h0000_2007, 2'd1, 1'b0, 32'h0, 3, 1'b0);         // R5 word split read
    access(32'h0000_2005, 2'd2, 1'b0, 32'h0, 2, 1'b0);         // R6 merge
  endtask

  task automatic t_wrap;
    access(32'hFFFF_FFFE, 2'd2, 1'b0, 32'h0, 3, 1'b0);         // R5 wrap to 0
    access(32'hFFFF_FFFF, 2'd1, 1'b1, 32'h0000_9A8B, 0, 1'b0); // R5 word wrap
  endtask

  task automatic t_size3;
    access(32'h0000_200A, 2'd3, 1'b1, 32'h0102_0304, 0, 1'b0); // R10
    access(32'h0000_200A, 2'd3, 1'b0, 32'h0, 0, 1'b0);         // R10
  endtask

  task automatic t_busy;
    access(32'h0000_2004, 2'd2, 1'b0, 32'h0, 5, 1'b1);         // R8 ignored
    access(32'h0000_2014, 2'd2, 1'b0, 32'h0, 0, 1'b0);         // R8 poke target untouched
  endtask

  initial begin
    for (int j = 0; j < 64; j++) refb[j] = pat(j);
    for (int j = 0; j < 16; j++)
      mem[j] = {pat(4*j+3), pat(4*j+2), pat(4*j+1), pat(4*j)};
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_wdata = '0; bus_ready = 1'b0; bus_rdata = '0;
    waits = 0; cnt = 0; nlog = 0; hold_bad = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_aligned;
    t_narrow;
    t_split;
    t_wrap;
    t_size3;
    t_busy;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule